// File: doc/BRIEF.md
# Segment Descriptor Cache

This block is a small direct-mapped store of segment descriptors for a segmented, paged address translator. When the table walker has fetched a two-word segment descriptor from memory, it presents the descriptor together with the virtual address that needed it. The block repacks the fields into a compact 64-bit entry, keeps the upper virtual address bits as a tag, and marks the entry valid.

For a lookup, the virtual address picks one of eight entries. A stored tag that matches and a set valid flag make a hit. One clock later the block returns the hit flag and the descriptor rebuilt in its memory layout. The rebuilt descriptor has its valid and present bits forced on, and its max-offset field is trimmed to the bits that the current page size uses.

Entries can be dropped one at a time, selected by the index bits of a virtual address, or all at once. Every storage update in a cycle takes effect before that cycle's lookup is resolved. The lookup therefore always sees the newest state.

Top module: `seg_desc_cache`

## Requirements
- R1: The cache has 8 entries selected by virtual address bits 19..17. Filling addresses that differ in these bits leaves every filled entry retrievable.
- R2: A lookup hits only when the selected entry's valid flag is set and its stored tag equals virtual address bits 31..20. Bits 16..0 of the lookup address do not affect the result.
- R3: On a hit, the returned low descriptor word carries the filled descriptor's access field (bits 31..24), max offset (23..18), R (5), cacheable (3), C (2) and M (1) at the same positions.
- R4: On a hit, bits 6 (V) and 0 (P) of the returned low word are 1 whatever was filled. Bits 4, 7 and 17..8 read 0.
- R5: On a hit, the returned high word carries the filled base address bits 31..3, and its bits 2..0 read 0.
- R6: page_size selects the page size: 0 is 2K, 1 is 4K, 2 and 3 are 8K. With 4K pages, returned bit 18 reads 0. With 8K pages, returned bits 19..18 read 0.
- R7: rsp_hit and rsp_dlo/rsp_dhi reflect a lookup one clock after lk_en. They read 0 when there was no lookup or the lookup missed.
- R8: A fill and a lookup in the same cycle resolve write-first. A lookup of the address being filled hits with the new descriptor.
- R9: inv_en clears the valid flag of the entry indexed by inv_va bits 19..17. Other entries are untouched. The invalidation beats a fill to the same index in the same cycle and is seen by a same-cycle lookup.
- R10: flush_all clears every valid flag in one cycle. It wins over a same-cycle fill, and later fills work normally.
- R11: After reset, every entry is invalid, so all lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write a descriptor into the cache |
| fill_va | input | 32 | Virtual address the descriptor belongs to |
| fill_dlo | input | 32 | Descriptor low word (flags, max offset, access) |
| fill_dhi | input | 32 | Descriptor high word (base address) |
| inv_en | input | 1 | Invalidate one entry |
| inv_va | input | 32 | Address whose index bits select the entry to invalidate |
| flush_all | input | 1 | Invalidate all entries |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| page_size | input | 2 | Current page size code |
| rsp_hit | output | 1 | Lookup hit, one cycle after lk_en |
| rsp_dlo | output | 32 | Rebuilt descriptor low word |
| rsp_dhi | output | 32 | Rebuilt descriptor high word |

## Verification
Each of the eight indices is filled with a pseudo-random descriptor and looked up again. This separates index decoding and field relocation errors, because every field carries distinct values in each entry. Lookups that change only the tag bits or only the offset bits separate tag comparison from index selection. All-ones and all-zero descriptors show the forced V/P bits and the cleared reserved bits, and the three page-size codes show max-offset trimming. Same-cycle combinations of fill, invalidate, flush and lookup pin down the write-first ordering and the priority among the updates.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned IDX_LSB = 17;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } sdc_entry_t;

  typedef enum logic [1:0] {
    PG_2K  = 2'd0,
    PG_4K  = 2'd1,
    PG_8K  = 2'd2,
    PG_8KX = 2'd3
  } pg_size_e;
endpackage

// File: rtl/sdc_pack.sv
module sdc_pack
  import sdc_pkg::*;
#(
  parameter int unsigned TAG_W = 12
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [31:0]      dlo,
  input  logic [31:0]      dhi,
  output sdc_entry_t       ent
);
  logic unused_fill_bits;
  assign unused_fill_bits = ^{dlo[17:6], dlo[4], dlo[0], dhi[2:0]};

  always_comb begin
    ent             = '0;
    ent.lo[31:24]   = dlo[31:24];
    ent.lo[23]      = dlo[5];
    ent.lo[22]      = dlo[1];
    ent.lo[20:15]   = dlo[23:18];
    ent.lo[TAG_W-1:0] = tag;
    ent.hi[31:3]    = dhi[31:3];
    ent.hi[2]       = dlo[3];
    ent.hi[1]       = dlo[2];
    ent.hi[0]       = 1'b1;
  end
endmodule

// File: rtl/sdc_store.sv
module sdc_store
  import sdc_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  sdc_entry_t       wr_ent,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_g,
  output sdc_entry_t       rd_ent
);
  sdc_entry_t         mem [ENTRIES];
  logic [ENTRIES-1:0] g_q;
  logic [ENTRIES-1:0] g_nxt;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
    logic hit_wr, hit_inv;
    assign hit_wr   = wr_en  && (wr_idx  == IDX_W'(e));
    assign hit_inv  = inv_en && (inv_idx == IDX_W'(e));
    assign g_nxt[e] = !flush && !hit_inv && (g_q[e] || hit_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g_q <= '0;
    else        g_q <= g_nxt;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ent;
  end

  // write-first read view
  assign rd_g   = g_nxt[rd_idx];
  assign rd_ent = (wr_en && (wr_idx == rd_idx)) ? wr_ent : mem[rd_idx];

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (g_q == '0)); // R10
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !g_q[$past(inv_idx)]); // R9
  AST_FILL_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && !(inv_en && (inv_idx == wr_idx))) |=> g_q[$past(wr_idx)]); // R1
endmodule

// File: rtl/sdc_unpack.sv
module sdc_unpack
  import sdc_pkg::*;
(
  input  sdc_entry_t  ent,
  input  logic [1:0]  page_size,
  output logic [31:0] dlo,
  output logic [31:0] dhi
);
  logic [5:0] off_mask;
  logic       unused_ent_bits;
  assign unused_ent_bits = ^{ent.lo[21], ent.lo[14:0], ent.hi[0]};

  always_comb begin
    case (pg_size_e'(page_size))
      PG_2K:   off_mask = 6'h3F;
      PG_4K:   off_mask = 6'h3E;
      default: off_mask = 6'h3C;
    endcase
  end

  always_comb begin
    dlo        = '0;
    dlo[31:24] = ent.lo[31:24];
    dlo[23:18] = ent.lo[20:15] & off_mask;
    dlo[6]     = 1'b1;
    dlo[5]     = ent.lo[23];
    dlo[3]     = ent.hi[2];
    dlo[2]     = ent.hi[1];
    dlo[1]     = ent.lo[22];
    dlo[0]     = 1'b1;
    dhi        = {ent.hi[31:3], 3'b000};
  end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import sdc_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned TAG_LSB = IDX_LSB + IDX_W,
  localparam int unsigned TAG_W   = VA_W - TAG_LSB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fill_en,
  input  logic [31:0] fill_va,
  input  logic [31:0] fill_dlo,
  input  logic [31:0] fill_dhi,
  input  logic        inv_en,
  input  logic [31:0] inv_va,
  input  logic        flush_all,
  input  logic        lk_en,
  input  logic [31:0] lk_va,
  input  logic [1:0]  page_size,
  output logic        rsp_hit,
  output logic [31:0] rsp_dlo,
  output logic [31:0] rsp_dhi
);
  logic unused_va_bits;
  assign unused_va_bits = ^{fill_va[IDX_LSB-1:0], inv_va[VA_W-1:TAG_LSB],
                            inv_va[IDX_LSB-1:0], lk_va[IDX_LSB-1:0]};

  sdc_entry_t  fill_ent, rd_ent;
  logic        rd_g, hit_c, hit_nxt, data_ce;
  logic [31:0] up_dlo, up_dhi, dlo_nxt, dhi_nxt;

  sdc_pack #(.TAG_W(TAG_W)) i_pack (
    .tag (fill_va[VA_W-1:TAG_LSB]),
    .dlo (fill_dlo),
    .dhi (fill_dhi),
    .ent (fill_ent)
  );

  sdc_store #(.ENTRIES(ENTRIES)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fill_en),
    .wr_idx  (fill_va[TAG_LSB-1:IDX_LSB]),
    .wr_ent  (fill_ent),
    .inv_en  (inv_en),
    .inv_idx (inv_va[TAG_LSB-1:IDX_LSB]),
    .flush   (flush_all),
    .rd_idx  (lk_va[TAG_LSB-1:IDX_LSB]),
    .rd_g    (rd_g),
    .rd_ent  (rd_ent)
  );

  sdc_unpack i_unpack (
    .ent       (rd_ent),
    .page_size (page_size),
    .dlo       (up_dlo),
    .dhi       (up_dhi)
  );

  // next-state
  always_comb begin
    hit_c   = rd_g && (rd_ent.lo[TAG_W-1:0] == lk_va[VA_W-1:TAG_LSB]);
    hit_nxt = lk_en && hit_c;
    dlo_nxt = hit_nxt ? up_dlo : '0;
    dhi_nxt = hit_nxt ? up_dhi : '0;
    data_ce = hit_nxt || rsp_hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit <= 1'b0;
      rsp_dlo <= '0;
      rsp_dhi <= '0;
    end else begin
      rsp_hit <= hit_nxt;
      if (data_ce) begin
        rsp_dlo <= dlo_nxt;
        rsp_dhi <= dhi_nxt;
      end
    end
  end

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> $past(lk_en)); // R7
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_dlo == '0 && rsp_dhi == '0)); // R7
  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && fill_en && (lk_va == fill_va) && !flush_all && !inv_en) |=> rsp_hit); // R8
  AST_VP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_dlo[6] && rsp_dlo[0] && rsp_dhi[2:0] == 3'b000)); // R4
endmodule

// File: tb/test_seg_desc_cache.sv
module test_seg_desc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fill_en, inv_en, flush_all, lk_en;
  logic [31:0] fill_va, fill_dlo, fill_dhi, inv_va, lk_va;
  logic [1:0]  page_size;
  logic        rsp_hit;
  logic [31:0] rsp_dlo, rsp_dhi;

  int compared = 0;
  int mismatched = 0;

  // behavioural model
  bit [31:0] m_lo [8];
  bit [31:0] m_hi [8];
  bit [11:0] m_tag[8];
  bit        m_g  [8];
  bit        e_hit;
  bit [31:0] e_lo, e_hi;
  string     e_req;
  bit [31:0] seed = 32'h1234_5678;
  bit [31:0] vas [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_desc_cache i_seg_desc_cache (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_va(fill_va), .fill_dlo(fill_dlo), .fill_dhi(fill_dhi),
    .inv_en(inv_en), .inv_va(inv_va), .flush_all(flush_all),
    .lk_en(lk_en), .lk_va(lk_va), .page_size(page_size),
    .rsp_hit(rsp_hit), .rsp_dlo(rsp_dlo), .rsp_dhi(rsp_dhi)
  );

  function automatic bit [31:0] rnd(input bit [31:0] s);
    bit [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // One cycle: compare the previous cycle's response, drive new inputs, advance model.
  task automatic cyc(input string req, input bit f_en, input bit [31:0] f_va,
                     input bit [31:0] f_lo, input bit [31:0] f_hi,
                     input bit i_en, input bit [31:0] i_va, input bit fl,
                     input bit l_en, input bit [31:0] l_va, input bit [1:0] ps);
    @(negedge clk);
    compared++;
    if (rsp_hit !== e_hit || rsp_dlo !== e_lo || rsp_dhi !== e_hi) begin
      mismatched++;
      $display("FAIL %s: hit=%0b dlo=%h dhi=%h expected hit=%0b dlo=%h dhi=%h",
               e_req, rsp_hit, rsp_dlo, rsp_dhi, e_hit, e_lo, e_hi);
    end
    fill_en = f_en; fill_va = f_va; fill_dlo = f_lo; fill_dhi = f_hi;
    inv_en = i_en; inv_va = i_va; flush_all = fl;
    lk_en = l_en; lk_va = l_va; page_size = ps;
    if (rst_n && f_en) begin
      m_lo[f_va[19:17]]  = f_lo;
      m_hi[f_va[19:17]]  = f_hi;
      m_tag[f_va[19:17]] = f_va[31:20];
      m_g[f_va[19:17]]   = 1'b1;
    end
    if (rst_n && i_en) m_g[i_va[19:17]] = 1'b0;
    if (!rst_n || fl) foreach (m_g[k]) m_g[k] = 1'b0;
    e_req = req;
    e_hit = 1'b0; e_lo = '0; e_hi = '0;
    if (rst_n && l_en && m_g[l_va[19:17]] && m_tag[l_va[19:17]] == l_va[31:20]) begin
      e_hit = 1'b1;
      e_lo  = (m_lo[l_va[19:17]] & 32'hFFFC_002E) | 32'h0000_0041;
      if (ps == 2'd1) e_lo[18] = 1'b0;
      if (ps >= 2'd2) e_lo[19:18] = 2'b00;
      e_hi  = m_hi[l_va[19:17]] & 32'hFFFF_FFF8;
    end
  endtask

  task automatic do_fill(input string req, input bit [31:0] va, input bit [31:0] lo, input bit [31:0] hi);
    cyc(req, 1, va, lo, hi, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_look(input string req, input bit [31:0] va, input bit [1:0] ps);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 1, va, ps);
  endtask
  task automatic idle(input string req);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fill_en = 0; inv_en = 0; flush_all = 0; lk_en = 0;
    fill_va = 0; fill_dlo = 0; fill_dhi = 0; inv_va = 0; lk_va = 0; page_size = 0;
    e_hit = 0; e_lo = 0; e_hi = 0; e_req = "R11";
    foreach (m_g[k]) m_g[k] = 1'b0;
    repeat (3) idle("R11");
    @(negedge clk) rst_n = 1'b1;
    // R11: everything misses after reset
    do_look("R11", 32'h0000_0000, 0);
    do_look("R11", 32'hFFFF_FFFF, 0);
    do_look("R11", 32'h1234_0000, 0);
    // R1 / R3: fill each index with distinct data
    for (int i = 0; i < 8; i++) begin
      seed = rnd(seed);
      vas[i] = {seed[31:20], i[2:0], seed[16:0]};
      seed = rnd(seed);
      begin
        bit [31:0] lo = seed;
        seed = rnd(seed);
        do_fill("R1", vas[i], lo, seed);
      end
    end
    for (int i = 0; i < 8; i++) do_look("R1", vas[i], 0);
    for (int i = 7; i >= 0; i--) do_look("R3", vas[i], 0);
    // R2: offset bits ignored, tag bits matter
    do_look("R2", vas[3] ^ 32'h0001_2345, 0);
    do_look("R2", vas[3] ^ 32'h0010_0000, 0);
    do_look("R2", vas[3] ^ 32'h8000_0000, 0);
    // R4 / R5: all ones and all zeros descriptors
    do_fill("R4", 32'hABC4_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_look("R4", 32'hABC4_0000, 0);
    do_look("R5", 32'hABC5_FFFF, 0);
    do_fill("R4", 32'h5554_0000, 32'h0000_0000, 32'h0000_0007);
    do_look("R4", 32'h5554_0000, 0);
    // R6: page size trimming of max offset
    do_fill("R6", 32'h1116_0000, 32'h00FC_0000, 32'h0000_1000);
    do_look("R6", 32'h1116_0000, 2'd0);
    do_look("R6", 32'h1116_0000, 2'd1);
    do_look("R6", 32'h1116_0000, 2'd2);
    do_look("R6", 32'h1116_0000, 2'd3);
    // R7: no lookup gives quiet outputs
    idle("R7");
    idle("R7");
    // R8: same-cycle fill and lookup
    cyc("R8", 1, 32'h777A_0000, 32'h5A5A_A5A5, 32'hC0DE_0008, 0, 0, 0, 1, 32'h777A_0000, 0);
    cyc("R8", 1, 32'h777A_0000, 32'h1234_5678, 32'h8765_4321, 0, 0, 0, 1, 32'h777B_1111, 1);
    // R9: invalidation
    do_fill("R9", vas[2], 32'hFFFF_FFFF, 32'h1111_1110);
    cyc("R9", 0, 0, 0, 0, 1, vas[2], 0, 1, vas[2], 0);
    do_look("R9", vas[1], 0);
    do_look("R9", vas[2], 0);
    cyc("R9", 1, vas[4], 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1, vas[4] ^ 32'hFFF0_0000, 0, 1, vas[4], 0);
    do_look("R9", vas[4], 0);
    do_look("R9", vas[6], 0);
    // R10: flush wins over same-cycle fill
    cyc("R10", 1, vas[0], 32'h1357_9BDF, 32'h2468_ACE0, 0, 0, 1, 1, vas[0], 0);
    for (int i = 0; i < 8; i++) do_look("R10", vas[i], 0);
    do_fill("R10", vas[5], 32'h0246_8ACE, 32'h1357_9BD8);
    do_look("R10", vas[5], 0);
    do_look("R10", vas[0], 0);
    idle("R7");
    idle("R7");
    summary();
    $finish;
  end
endmodule